// File: doc/BRIEF.md
# Cascadable BCD Seven-Segment Decoder

This block turns one or more 4-bit BCD codes into active-high drives for seven-segment displays. Each digit has three overrides. An active-low blank input darkens the digit. An active-low lamp test lights all segments of the digit. A ripple-blanking pair lets a digit go dark when it shows a zero, and lets it tell its lower neighbour that it did so. Codes 10 to 14 show fixed partial glyphs, and code 15 is fully dark.

The top module holds `N_DIGITS` digit decoders in a chain, most significant digit first. The ripple input of the most significant digit is tied low (when leading suppression is on). Each digit's ripple output feeds the ripple input of the next lower digit. The least significant digit never suppresses its zero, so a value of zero still shows a single "0". The segment outputs and ripple outputs are registered: one always_comb computes the next state and one always_ff stores it.

An option models the classic shared blank/ripple pin. With that option, the ripple output is also pulled low whenever the digit's own blank input is low.

Top module: `seg_bcd_display`

## Requirements
- R1: Digit `k` occupies `seg_q[7k+6:7k]`, with segment a in bit 0 through segment g in bit 6. With no override active, codes 0 to 9 light: 0 a b c d e f; 1 b c; 2 a b d e g; 3 a b c d g; 4 b c f g; 5 a c d f g; 6 c d e f g; 7 a b c; 8 all; 9 a b c f g.
- R2: With no override active, codes 10 to 15 light: 10 d e g; 11 c d g; 12 b f g; 13 a d f g; 14 d e f g; 15 nothing.
- R3: A low on `blank_n[k]` darkens digit k regardless of its code, its lamp test and its ripple input.
- R4: When `blank_n[k]` is high and `lamp_test_n[k]` is low, all seven segments of digit k are lit, and `rbo_n_q[k]` stays high.
- R5: When lamp test is inactive, the digit's ripple input is low and its code is 0, the digit is dark and `rbo_n_q[k]` goes low.
- R6: A code-0 digit whose ripple input is high shows the "0" glyph. Outside the suppression case of R5, `rbo_n_q[k]` is high (apart from R8).
- R7: The ripple input of the most significant digit is low when `SUPPRESS_LEADING` is 1. Each other digit except digit 0 takes its ripple input from the ripple output of the next more significant digit. Digit 0's ripple input is always high.
- R8: With `MERGE_BI_RBO` = 1, `rbo_n_q[k]` is also low whenever `blank_n[k]` is low, and that low feeds the next digit's ripple input.
- R9: Outputs change one clock after the inputs. During reset all segments are off and every `rbo_n_q` bit is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bcd_in | input | 4*N_DIGITS | BCD code per digit, digit k in bits 4k+3:4k, digit 0 least significant |
| blank_n | input | N_DIGITS | Active-low blank per digit |
| lamp_test_n | input | N_DIGITS | Active-low lamp test per digit |
| seg_q | output | 7*N_DIGITS | Registered segment drives, a..g in bits 0..6 of each digit slice |
| rbo_n_q | output | N_DIGITS | Registered active-low ripple-blanking output per digit |

## Verification
The bench goes after the priority order. Blank must beat lamp test, so a design that checks lamp test first lights a digit that should be dark. Lamp test must beat suppression, so a design that gets this wrong leaves leading zeros dark during a lamp test or pulls their ripple outputs low.

Patterns such as 0000, 0100 and 0010 check the chain. A design that fails to stop the chain at a non-zero digit blanks interior zeros. A design that ties digit 0 wrongly shows a zero value as four dark digits.

Both the split and the merged ripple pin are driven side by side. Under the wired model, a blanked leading digit must still suppress the zeros below it.

// File: rtl/seg_pkg.sv
package seg_pkg;

    localparam int SEG_W = 7;
    localparam int BCD_W = 4;

    typedef logic [SEG_W-1:0] seg_t;
    typedef logic [BCD_W-1:0] bcd_t;

    // bit 0 = a ... bit 6 = g
    localparam seg_t SEG_ALL  = 7'h7F;
    localparam seg_t SEG_NONE = 7'h00;

    typedef struct packed {
        seg_t seg;
        logic rbo_n;
    } digit_out_t;

    function automatic seg_t glyph_of(input bcd_t code);
        seg_t s;
        case (code)
            4'd0:    s = 7'h3F;
            4'd1:    s = 7'h06;
            4'd2:    s = 7'h5B;
            4'd3:    s = 7'h4F;
            4'd4:    s = 7'h66;
            4'd5:    s = 7'h6D;
            4'd6:    s = 7'h7C;
            4'd7:    s = 7'h07;
            4'd8:    s = 7'h7F;
            4'd9:    s = 7'h67;
            4'd10:   s = 7'h58;
            4'd11:   s = 7'h4C;
            4'd12:   s = 7'h62;
            4'd13:   s = 7'h69;
            4'd14:   s = 7'h78;
            default: s = 7'h00;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/seg_digit_dec.sv
module seg_digit_dec
    import seg_pkg::*;
#(
    parameter bit MERGE_BI_RBO = 1'b0
) (
    input  logic [BCD_W-1:0] code,
    input  logic             blank_n,
    input  logic             lamp_test_n,
    input  logic             rbi_n,
    output digit_out_t       dout
);

    logic is_zero;
    logic suppress;
    logic rbo_raw_n;

    assign is_zero  = (code == '0);
    // suppression only when no higher-priority override is active
    assign suppress = blank_n && lamp_test_n && !rbi_n && is_zero;

    always_comb begin
        if (!blank_n) begin
            dout.seg = SEG_NONE;
        end else if (!lamp_test_n) begin
            dout.seg = SEG_ALL;
        end else if (suppress) begin
            dout.seg = SEG_NONE;
        end else begin
            dout.seg = glyph_of(code);
        end
    end

    assign rbo_raw_n = !suppress;

    generate
        if (MERGE_BI_RBO) begin : g_wired
            assign dout.rbo_n = rbo_raw_n & blank_n;
        end else begin : g_split
            assign dout.rbo_n = rbo_raw_n;
        end
    endgenerate

endmodule

// File: rtl/seg_ripple_chain.sv
module seg_ripple_chain
    import seg_pkg::*;
#(
    parameter int N_DIGITS         = 4,
    parameter bit SUPPRESS_LEADING = 1'b1,
    parameter bit MERGE_BI_RBO     = 1'b0,
    localparam int BCD_BITS        = N_DIGITS * BCD_W,
    localparam int SEG_BITS        = N_DIGITS * SEG_W
) (
    input  logic [BCD_BITS-1:0] bcd_in,
    input  logic [N_DIGITS-1:0] blank_n,
    input  logic [N_DIGITS-1:0] lamp_test_n,
    output logic [SEG_BITS-1:0] seg,
    output logic [N_DIGITS-1:0] rbo_n
);

    logic [N_DIGITS-1:0] rbi_n;
    digit_out_t          dout [N_DIGITS];

    generate
        for (genvar g = 0; g < N_DIGITS; g++) begin : g_digit
            if (g == 0) begin : g_lsd
                assign rbi_n[g] = 1'b1;
            end else if (g == N_DIGITS - 1) begin : g_msd
                assign rbi_n[g] = !SUPPRESS_LEADING;
            end else begin : g_mid
                assign rbi_n[g] = dout[g+1].rbo_n;
            end

            seg_digit_dec #(
                .MERGE_BI_RBO(MERGE_BI_RBO)
            ) u_dec (
                .code        (bcd_in[g*BCD_W +: BCD_W]),
                .blank_n     (blank_n[g]),
                .lamp_test_n (lamp_test_n[g]),
                .rbi_n       (rbi_n[g]),
                .dout        (dout[g])
            );

            assign seg[g*SEG_W +: SEG_W] = dout[g].seg;
            assign rbo_n[g]              = dout[g].rbo_n;
        end
    endgenerate

endmodule

// File: rtl/seg_bcd_display.sv
module seg_bcd_display
    import seg_pkg::*;
#(
    parameter int N_DIGITS         = 4,
    parameter bit SUPPRESS_LEADING = 1'b1,
    parameter bit MERGE_BI_RBO     = 1'b0,
    localparam int BCD_BITS        = N_DIGITS * BCD_W,
    localparam int SEG_BITS        = N_DIGITS * SEG_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [BCD_BITS-1:0] bcd_in,
    input  logic [N_DIGITS-1:0] blank_n,
    input  logic [N_DIGITS-1:0] lamp_test_n,
    output logic [SEG_BITS-1:0] seg_q,
    output logic [N_DIGITS-1:0] rbo_n_q
);

    typedef struct packed {
        logic [SEG_BITS-1:0] seg;
        logic [N_DIGITS-1:0] rbo_n;
    } disp_state_t;

    disp_state_t         state_d;
    disp_state_t         state_q;
    logic [SEG_BITS-1:0] chain_seg;
    logic [N_DIGITS-1:0] chain_rbo_n;

    seg_ripple_chain #(
        .N_DIGITS         (N_DIGITS),
        .SUPPRESS_LEADING (SUPPRESS_LEADING),
        .MERGE_BI_RBO     (MERGE_BI_RBO)
    ) u_chain (
        .bcd_in      (bcd_in),
        .blank_n     (blank_n),
        .lamp_test_n (lamp_test_n),
        .seg         (chain_seg),
        .rbo_n       (chain_rbo_n)
    );

    always_comb begin
        state_d       = state_q;
        state_d.seg   = chain_seg;
        state_d.rbo_n = chain_rbo_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.seg   <= '0;
            state_q.rbo_n <= '1;
        end else begin
            state_q <= state_d;
        end
    end

    assign seg_q   = state_q.seg;
    assign rbo_n_q = state_q.rbo_n;

endmodule

// File: rtl/seg_bcd_display_chk.sv
module seg_bcd_display_chk #(
    parameter int N_DIGITS     = 4,
    parameter bit MERGE_BI_RBO = 1'b0
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [N_DIGITS*4-1:0]   bcd_in,
    input logic [N_DIGITS-1:0]     blank_n,
    input logic [N_DIGITS-1:0]     lamp_test_n,
    input logic [N_DIGITS*7-1:0]   seg_q,
    input logic [N_DIGITS-1:0]     rbo_n_q
);

    generate
        for (genvar k = 0; k < N_DIGITS; k++) begin : g_chk
            AST_BLANK_DARK: assert property (@(posedge clk) disable iff (!rst_n)
                !blank_n[k] |=> (seg_q[k*7 +: 7] == 7'h00)); // R3

            AST_LAMP_ALL_ON: assert property (@(posedge clk) disable iff (!rst_n)
                (blank_n[k] && !lamp_test_n[k]) |=> (seg_q[k*7 +: 7] == 7'h7F && rbo_n_q[k])); // R4

            AST_RBO_LOW_DARK: assert property (@(posedge clk) disable iff (!rst_n)
                !rbo_n_q[k] |-> (seg_q[k*7 +: 7] == 7'h00)); // R5

            AST_CODE15_DARK: assert property (@(posedge clk) disable iff (!rst_n)
                (bcd_in[k*4 +: 4] == 4'hF && lamp_test_n[k]) |=> (seg_q[k*7 +: 7] == 7'h00)); // R2

            AST_NONZERO_RBO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
                (blank_n[k] && bcd_in[k*4 +: 4] != 4'h0) |=> rbo_n_q[k]); // R6
        end
    endgenerate

    AST_LSD_NO_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n)
        (blank_n[0] && lamp_test_n[0] && bcd_in[3:0] == 4'h0) |=> (seg_q[6:0] == 7'h3F)); // R7

    if (MERGE_BI_RBO) begin : g_wired_chk
        AST_WIRED_RBO: assert property (@(posedge clk) disable iff (!rst_n)
            !blank_n[0] |=> !rbo_n_q[0]); // R8
    end

endmodule

bind seg_bcd_display seg_bcd_display_chk #(
    .N_DIGITS     (N_DIGITS),
    .MERGE_BI_RBO (MERGE_BI_RBO)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bcd_in      (bcd_in),
    .blank_n     (blank_n),
    .lamp_test_n (lamp_test_n),
    .seg_q       (seg_q),
    .rbo_n_q     (rbo_n_q)
);

// File: tb/tb_seg_bcd_display.sv
module tb_seg_bcd_display;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 4;
    localparam int WATCHDOG   = 100000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N*4-1:0]  bcd_in = '0;
    logic [N-1:0]    blank_n = '1;
    logic [N-1:0]    lamp_test_n = '1;
    logic [N*7-1:0]  seg_s, seg_w;
    logic [N-1:0]    rbo_s, rbo_w;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    string letters [16];
    logic [6:0] exp_seg [N];
    logic       exp_rbo [N];
    string      exp_tag [N];
    string      rbo_tag [N];

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_bcd_display #(.N_DIGITS(N), .MERGE_BI_RBO(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .bcd_in(bcd_in), .blank_n(blank_n),
        .lamp_test_n(lamp_test_n), .seg_q(seg_s), .rbo_n_q(rbo_s));

    seg_bcd_display #(.N_DIGITS(N), .MERGE_BI_RBO(1'b1)) dut_wired (
        .clk(clk), .rst_n(rst_n), .bcd_in(bcd_in), .blank_n(blank_n),
        .lamp_test_n(lamp_test_n), .seg_q(seg_w), .rbo_n_q(rbo_w));

    function automatic logic [6:0] from_letters(input string s);
        logic [6:0] v = '0;
        for (int i = 0; i < s.len(); i++) v[s[i] - "a"] = 1'b1;
        return v;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [6:0] act, input logic [6:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // behavioural model of one chain, MSD first
    task automatic model(input bit wired);
        bit ripple;
        bit rbi;
        ripple = 1'b1;
        for (int d = N-1; d >= 0; d--) begin
            logic [3:0] c = bcd_in[d*4 +: 4];
            bit sup;
            if (d == 0)          rbi = 1'b1;       // R7
            else if (d == N-1)   rbi = 1'b0;
            else                 rbi = ripple;
            sup = blank_n[d] && lamp_test_n[d] && !rbi && (c == 0);
            if (!blank_n[d]) begin
                exp_seg[d] = '0; exp_tag[d] = "R3";
            end else if (!lamp_test_n[d]) begin
                exp_seg[d] = 7'h7F; exp_tag[d] = "R4";
            end else if (sup) begin
                exp_seg[d] = '0; exp_tag[d] = "R5";
            end else begin
                exp_seg[d] = from_letters(letters[c]);
                exp_tag[d] = (c < 10) ? "R1" : "R2";
            end
            exp_rbo[d] = !sup;
            rbo_tag[d] = sup ? "R5" : "R6";
            if (wired && !blank_n[d]) begin
                exp_rbo[d] = 1'b0; rbo_tag[d] = "R8";
            end
            ripple = exp_rbo[d];
        end
    endtask

    task automatic compare(input bit wired);
        model(wired);
        for (int d = 0; d < N; d++) begin
            logic [6:0] a = wired ? seg_w[d*7 +: 7] : seg_s[d*7 +: 7];
            logic       r = wired ? rbo_w[d] : rbo_s[d];
            check(a == exp_seg[d], exp_tag[d], wired ? "wired seg" : "split seg", a, exp_seg[d]);
            check(r == exp_rbo[d], rbo_tag[d], wired ? "wired rbo" : "split rbo",
                  {6'b0, r}, {6'b0, exp_rbo[d]});
        end
    endtask

    // drive at negedge, registered at the next posedge, compared at the following negedge (R9)
    task automatic apply(input logic [N*4-1:0] b, input logic [N-1:0] bl, input logic [N-1:0] lt);
        @(negedge clk);
        bcd_in = b; blank_n = bl; lamp_test_n = lt;
        @(negedge clk);
        compare(1'b0);
        compare(1'b1);
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        letters[0] = "abcdef"; letters[1] = "bc";   letters[2] = "abdeg";
        letters[3] = "abcdg";  letters[4] = "bcfg"; letters[5] = "acdfg";
        letters[6] = "cdefg";  letters[7] = "abc";  letters[8] = "abcdefg";
        letters[9] = "abcfg";  letters[10] = "deg"; letters[11] = "cdg";
        letters[12] = "bfg";   letters[13] = "adfg"; letters[14] = "defg";
        letters[15] = "";

        // R9: reset state, with inputs that would light everything
        lamp_test_n = '0;
        repeat (3) @(negedge clk);
        check(seg_s == '0 && seg_w == '0, "R9", "reset seg", seg_s[6:0], 7'h00);
        check(rbo_s == '1 && rbo_w == '1, "R9", "reset rbo", {3'b0, rbo_s}, 7'h0F);
        @(negedge clk);
        rst_n = 1'b1;
        lamp_test_n = '1;

        // R1 R2: every code on every digit, plain and with a non-zero MSD
        for (int c = 0; c < 16; c++) begin
            apply({4{c[3:0]}}, '1, '1);
            apply({4'h1, {3{c[3:0]}}}, '1, '1);
        end

        // R5 R7: chain patterns
        apply(16'h0000, '1, '1);
        apply(16'h0100, '1, '1);
        apply(16'h0010, '1, '1);
        apply(16'h0001, '1, '1);
        apply(16'h1000, '1, '1);
        apply(16'h0F00, '1, '1);

        // R3 R4 R8: every blank / lamp-test combination on every digit, for zero and non-zero codes
        for (int m = 0; m < 256; m++) begin
            logic [7:0] mm = m[7:0];
            apply(16'h0000, mm[3:0], mm[7:4]);
            apply(16'h0705, mm[3:0], mm[7:4]);
        end

        // mixed patterns
        for (int i = 0; i < 400; i++) begin
            logic [15:0] b = 16'($urandom());
            logic [3:0]  bl = 4'($urandom()) | 4'($urandom());
            logic [3:0]  lt = 4'($urandom()) | 4'($urandom());
            if (i % 3 == 0) b[15:8] = 8'h00;
            apply(b, bl, lt);
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule